// File: doc/BRIEF.md
# Mesh Router Switch Allocator

This block decides, once per clock, which buffered flits cross a five-port mesh router's crossbar. The ports are numbered 0 north, 1 east, 2 south, 3 west and 4 local. Each input port holds four virtual channels (VCs). A VC competes when it holds a flit and its downstream credit is available, and it names the output port it wants. Allocation is separable. A first stage picks one contender per input port. A second stage then settles conflicts among the input ports that want the same output.

Both stages use least-recently-granted matrix arbiters, so every contender is eventually served. The grants are combinational from the current requests, so allocation fits inside the router's single logic cycle. The arbiter priority state is updated at the following clock edge. The VC grant vector drives buffer dequeue, and the per-output select vector drives the crossbar. A parameter mask marks output ports that do not exist, such as the outward ports of a router on the mesh edge.

Top module: `sa_switch_alloc`

## Requirements
- R1: While `rst_n` is low, `vc_grant` and `out_sel` are all zero, even with every VC requesting. Reset puts every arbiter in the order where a lower index has the higher priority.
- R2: VC v of input p (bit p*4+v) can be granted only in a cycle where both `vc_valid` and `vc_ready` are high for that bit.
- R3: At most one bit of `vc_grant` is high within each input port's group of four.
- R4: Bit o*5+i of `out_sel` means output o takes input i. Each output row has at most one bit set. A VC is granted only together with the `out_sel` bit of the output encoded in its 3-bit field of `vc_outport` at bits (p*4+v)*3 upward.
- R5: Within an input port, the first stage grants the requesting VC that was granted least recently. A VC that is granted drops below every other VC of its port.
- R6: The first-stage order of an input port changes only when that port's pick also wins the second stage. A pick that loses at the output leaves the order untouched.
- R7: For each output, the second stage grants the contending input port that won that output least recently. The winner drops below all other ports for that output.
- R8: A request whose output field names a port disabled in `OUT_EN`, or a value of 5 or more, is ignored. It gets no grant and does not block other VCs of the same port.
- R9: With every VC requesting the same output continuously, each of the 20 VCs is granted within 20 consecutive grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the arbiter state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vc_valid | input | 20 | One bit per VC (p*4+v): a flit is buffered |
| vc_ready | input | 20 | One bit per VC: a downstream credit is available |
| vc_outport | input | 60 | 3-bit requested output per VC, field p*4+v |
| vc_grant | output | 20 | One-hot per input port: dequeue this VC |
| out_sel | output | 25 | Crossbar select, bit o*5+i: output o takes input i |

## Verification
Two things can happen in the same cycle. An input port's first-stage pick can lose the output to another port, while a different output grants the same port's other traffic or grants nothing. The fairness rotation must then advance at the output but stay put at the input. The bench sets this up by having several input ports aim their picks at one output while a second VC of the losing port waits behind the pick. A reference model of the least-recently-granted orders predicts the grants of every cycle. Any wrong rotation shows up a cycle or more later as a grant to the wrong VC.

// File: rtl/sa_pkg.sv
package sa_pkg;
   // router direction encoding used on vc_outport and out_sel
   typedef enum logic [2:0] {
      DIR_NORTH = 3'd0,
      DIR_EAST  = 3'd1,
      DIR_SOUTH = 3'd2,
      DIR_WEST  = 3'd3,
      DIR_LOCAL = 3'd4
   } sa_dir_e;

   localparam int SA_DIR_COUNT = 5;

   function automatic int sa_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sa_matrix_arb.sv
module sa_matrix_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         upd_en,
   output logic [N-1:0] gnt
);
   // beats[a][b] high: requester a currently outranks requester b
   logic beats [N][N];

   for (genvar a = 0; a < N; a++) begin : g_row
      for (genvar b = 0; b < N; b++) begin : g_col
         if (a < b) begin : g_state
            logic t_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  t_q <= 1'b1;
               end else if (upd_en) begin
                  if (gnt[a]) begin
                     t_q <= 1'b0;
                  end else if (gnt[b]) begin
                     t_q <= 1'b1;
                  end
               end
            end
            assign beats[a][b] = t_q;
            assign beats[b][a] = ~t_q;
         end else if (a == b) begin : g_diag
            assign beats[a][b] = 1'b0;
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_gnt
      logic [N-1:0] blk;
      for (genvar j = 0; j < N; j++) begin : g_blk
         assign blk[j] = req[j] & beats[j][i];
      end
      assign gnt[i] = req[i] & ~(|blk);
   end
endmodule

// File: rtl/sa_in_port.sv
module sa_in_port #(
   parameter int             NUM_VCS   = 4,
   parameter int             NUM_PORTS = 5,
   parameter int             DEST_W    = 3,
   parameter logic [NUM_PORTS-1:0] OUT_EN = '1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_VCS-1:0]          vc_valid,
   input  logic [NUM_VCS-1:0]          vc_ready,
   input  logic [NUM_VCS*DEST_W-1:0]   vc_dest,
   input  logic                        won,
   output logic                        req_out,
   output logic [DEST_W-1:0]           dest_out,
   output logic [NUM_VCS-1:0]          pick
);
   logic [NUM_VCS-1:0] dest_ok;
   logic [NUM_VCS-1:0] elig;

   for (genvar v = 0; v < NUM_VCS; v++) begin : g_elig
      always_comb begin
         dest_ok[v] = 1'b0;
         for (int k = 0; k < NUM_PORTS; k++) begin
            if (vc_dest[v*DEST_W +: DEST_W] == DEST_W'(k) && OUT_EN[k]) begin
               dest_ok[v] = 1'b1;
            end
         end
      end
      assign elig[v] = vc_valid[v] & vc_ready[v] & dest_ok[v];
   end

   if (NUM_VCS == 1) begin : g_single
      assign pick = elig;
   end else begin : g_arb
      sa_matrix_arb #(.N(NUM_VCS)) u_arb (
         .clk    (clk),
         .rst_n  (rst_n),
         .req    (elig),
         .upd_en (won),
         .gnt    (pick)
      );
   end

   always_comb begin
      dest_out = '0;
      for (int v = 0; v < NUM_VCS; v++) begin
         dest_out |= vc_dest[v*DEST_W +: DEST_W] & {DEST_W{pick[v]}};
      end
   end

   assign req_out = |pick;
endmodule

// File: rtl/sa_out_port.sv
module sa_out_port #(
   parameter int NUM_PORTS = 5,
   parameter int DEST_W    = 3,
   parameter int IDX       = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          req_valid,
   input  logic [NUM_PORTS*DEST_W-1:0]   req_dest,
   output logic [NUM_PORTS-1:0]          sel
);
   logic [NUM_PORTS-1:0] want;

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_want
      assign want[i] = req_valid[i] &&
                       (req_dest[i*DEST_W +: DEST_W] == DEST_W'(IDX));
   end

   sa_matrix_arb #(.N(NUM_PORTS)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (want),
      .upd_en (|want),
      .gnt    (sel)
   );
endmodule

// File: rtl/sa_switch_alloc.sv
module sa_switch_alloc #(
   parameter int NUM_PORTS = sa_pkg::SA_DIR_COUNT,
   parameter int NUM_VCS   = 4,
   parameter logic [NUM_PORTS-1:0] OUT_EN = '1,
   localparam int DEST_W   = sa_pkg::sa_width(NUM_PORTS),
   localparam int NUM_REQ  = NUM_PORTS * NUM_VCS
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_REQ-1:0]            vc_valid,
   input  logic [NUM_REQ-1:0]            vc_ready,
   input  logic [NUM_REQ*DEST_W-1:0]     vc_outport,
   output logic [NUM_REQ-1:0]            vc_grant,
   output logic [NUM_PORTS*NUM_PORTS-1:0] out_sel
);
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("sa_switch_alloc: NUM_PORTS must be at least 2");
   end
   if (NUM_VCS < 1) begin : g_bad_vcs
      $error("sa_switch_alloc: NUM_VCS must be at least 1");
   end
   if (OUT_EN == '0) begin : g_bad_mask
      $error("sa_switch_alloc: OUT_EN enables no output");
   end

   logic [NUM_PORTS-1:0]           in_req;
   logic [NUM_PORTS*DEST_W-1:0]    in_dest;
   logic [NUM_REQ-1:0]             pick;
   logic [NUM_PORTS-1:0]           won;
   logic [NUM_PORTS*NUM_PORTS-1:0] sel_raw;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_in
      sa_in_port #(
         .NUM_VCS   (NUM_VCS),
         .NUM_PORTS (NUM_PORTS),
         .DEST_W    (DEST_W),
         .OUT_EN    (OUT_EN)
      ) u_in (
         .clk      (clk),
         .rst_n    (rst_n),
         .vc_valid (vc_valid[p*NUM_VCS +: NUM_VCS]),
         .vc_ready (vc_ready[p*NUM_VCS +: NUM_VCS]),
         .vc_dest  (vc_outport[p*NUM_VCS*DEST_W +: NUM_VCS*DEST_W]),
         .won      (won[p]),
         .req_out  (in_req[p]),
         .dest_out (in_dest[p*DEST_W +: DEST_W]),
         .pick     (pick[p*NUM_VCS +: NUM_VCS])
      );
   end

   for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
      sa_out_port #(
         .NUM_PORTS (NUM_PORTS),
         .DEST_W    (DEST_W),
         .IDX       (o)
      ) u_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_valid (in_req),
         .req_dest  (in_dest),
         .sel       (sel_raw[o*NUM_PORTS +: NUM_PORTS])
      );
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_won
      logic [NUM_PORTS-1:0] col;
      for (genvar o = 0; o < NUM_PORTS; o++) begin : g_col
         assign col[o] = sel_raw[o*NUM_PORTS + p];
      end
      assign won[p] = |col;
      assign vc_grant[p*NUM_VCS +: NUM_VCS] =
         pick[p*NUM_VCS +: NUM_VCS] & {NUM_VCS{won[p] & rst_n}};
   end

   assign out_sel = sel_raw & {(NUM_PORTS*NUM_PORTS){rst_n}};
endmodule

// File: rtl/sa_switch_alloc_chk.sv
module sa_switch_alloc_chk #(
   parameter int NUM_PORTS = 5,
   parameter int NUM_VCS   = 4,
   parameter logic [NUM_PORTS-1:0] OUT_EN = '1,
   parameter int DEST_W    = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_PORTS*NUM_VCS-1:0]   vc_valid,
   input logic [NUM_PORTS*NUM_VCS-1:0]   vc_ready,
   input logic [NUM_PORTS*NUM_VCS*DEST_W-1:0] vc_outport,
   input logic [NUM_PORTS*NUM_VCS-1:0]   vc_grant,
   input logic [NUM_PORTS*NUM_PORTS-1:0] out_sel
);
   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> (vc_grant == '0 && out_sel == '0)); // R1

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(vc_grant[p*NUM_VCS +: NUM_VCS])); // R3
      for (genvar v = 0; v < NUM_VCS; v++) begin : g_v
         localparam int B = p*NUM_VCS + v;
         AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            vc_grant[B] |-> (vc_valid[B] && vc_ready[B])); // R2
         AST_GRANT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
            vc_grant[B] |-> out_sel[int'(vc_outport[B*DEST_W +: DEST_W])*NUM_PORTS + p]); // R4
      end
   end

   for (genvar o = 0; o < NUM_PORTS; o++) begin : g_o
      AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(out_sel[o*NUM_PORTS +: NUM_PORTS])); // R4
      if (!OUT_EN[o]) begin : g_off
         AST_OUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            out_sel[o*NUM_PORTS +: NUM_PORTS] == '0); // R8
      end
   end
endmodule

bind sa_switch_alloc sa_switch_alloc_chk #(
   .NUM_PORTS (NUM_PORTS),
   .NUM_VCS   (NUM_VCS),
   .OUT_EN    (OUT_EN),
   .DEST_W    (DEST_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vc_valid   (vc_valid),
   .vc_ready   (vc_ready),
   .vc_outport (vc_outport),
   .vc_grant   (vc_grant),
   .out_sel    (out_sel)
);

// File: tb/sa_switch_alloc_test.sv
module sa_switch_alloc_test;
   import sa_pkg::*;

   localparam int P  = 5;
   localparam int V  = 4;
   localparam int DW = 3;
   localparam int NR = P * V;
   localparam logic [P-1:0] EN = 5'b11110;   // edge router: no north port

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NR-1:0]    vv = '0;
   logic [NR-1:0]    vr = '0;
   logic [NR*DW-1:0] vd = '0;
   logic [NR-1:0]    g;
   logic [P*P-1:0]   s;

   always #10 clk = ~clk;

   sa_switch_alloc #(.NUM_PORTS(P), .NUM_VCS(V), .OUT_EN(EN)) uut (
      .clk(clk), .rst_n(rst_n), .vc_valid(vv), .vc_ready(vr),
      .vc_outport(vd), .vc_grant(g), .out_sel(s)
   );

   int n_run = 0;
   int n_fail = 0;
   int ord1 [P][V];
   int ord2 [P][P];
   logic [NR-1:0]  q_g [$];
   logic [P*P-1:0] q_s [$];
   string          q_t [$];
   bit             starve_on = 1'b0;
   logic [NR-1:0]  seen = '0;

   function automatic int dest_of(logic [NR*DW-1:0] d, int p, int v);
      return int'(d[(p*V+v)*DW +: DW]);
   endfunction

   function automatic logic [NR*DW-1:0] all_dest(int o);
      logic [NR*DW-1:0] d = '0;
      for (int k = 0; k < NR; k++) d[k*DW +: DW] = DW'(o);
      return d;
   endfunction

   task automatic to_back1(int p, int who);
      int pos = 0;
      for (int k = 0; k < V; k++) if (ord1[p][k] == who) pos = k;
      for (int k = pos; k < V-1; k++) ord1[p][k] = ord1[p][k+1];
      ord1[p][V-1] = who;
   endtask

   task automatic to_back2(int o, int who);
      int pos = 0;
      for (int k = 0; k < P; k++) if (ord2[o][k] == who) pos = k;
      for (int k = pos; k < P-1; k++) ord2[o][k] = ord2[o][k+1];
      ord2[o][P-1] = who;
   endtask

   // driver: applies one cycle of stimulus and queues the predicted grants
   task automatic drive(logic [NR-1:0] v, logic [NR-1:0] r,
                        logic [NR*DW-1:0] d, string tag);
      int w1 [P];
      int w2 [P];
      logic [NR-1:0]  eg = '0;
      logic [P*P-1:0] es = '0;
      @(negedge clk);
      vv = v; vr = r; vd = d;
      if (rst_n) begin
         for (int p = 0; p < P; p++) begin
            w1[p] = -1;
            for (int k = 0; k < V; k++) begin
               int c = ord1[p][k];
               int dd = dest_of(d, p, c);
               if (w1[p] < 0 && v[p*V+c] && r[p*V+c] && dd < P && EN[dd]) w1[p] = c;
            end
         end
         for (int o = 0; o < P; o++) begin
            w2[o] = -1;
            for (int k = 0; k < P; k++) begin
               int ip = ord2[o][k];
               if (w2[o] < 0 && w1[ip] >= 0 && dest_of(d, ip, w1[ip]) == o) w2[o] = ip;
            end
         end
         for (int o = 0; o < P; o++) begin
            if (w2[o] >= 0) begin
               es[o*P + w2[o]] = 1'b1;
               eg[w2[o]*V + w1[w2[o]]] = 1'b1;
               to_back1(w2[o], w1[w2[o]]);
               to_back2(o, w2[o]);
            end
         end
      end
      q_g.push_back(eg);
      q_s.push_back(es);
      q_t.push_back(tag);
   endtask

   // monitor: compares the outputs against the queued prediction
   initial begin
      logic [NR-1:0]  eg;
      logic [P*P-1:0] es;
      string t;
      forever begin
         @(negedge clk);
         #2;
         if (q_g.size() > 0) begin
            eg = q_g.pop_front();
            es = q_s.pop_front();
            t  = q_t.pop_front();
            n_run++;
            if (g !== eg || s !== es) begin
               n_fail++;
               $display("FAIL %s: grant=%h sel=%h expected grant=%h sel=%h",
                        t, g, s, eg, es);
            end
            if (starve_on) seen |= g;
         end
      end
   end

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [NR*DW-1:0] d;
      for (int p = 0; p < P; p++) begin
         for (int k = 0; k < V; k++) ord1[p][k] = k;
         for (int k = 0; k < P; k++) ord2[p][k] = k;
      end

      // R1: grants stay low in reset with all requests present
      drive('1, '1, all_dest(DIR_LOCAL), "R1 reset quiet");
      drive('1, '1, all_dest(DIR_EAST), "R1 reset quiet");
      @(posedge clk);
      #1 rst_n = 1'b1;

      // R2: valid and ready both needed
      drive('0, '0, '0, "R2 idle");
      drive(NR'(1) << 6, '0, all_dest(DIR_LOCAL), "R2 valid without ready");
      drive('0, NR'(1) << 6, all_dest(DIR_LOCAL), "R2 ready without valid");
      drive(NR'(1) << 6, NR'(1) << 6, all_dest(DIR_LOCAL), "R2 eligible VC granted");

      // R5: VC rotation inside input port 0
      repeat (6) drive(NR'(4'hF), NR'(4'hF), all_dest(DIR_SOUTH), "R5 vc order");

      // R7: input rotation at output west
      repeat (7) drive(NR'(20'h11111), '1, all_dest(DIR_WEST), "R7 port order");

      // R6: port 0 loses the output while its second VC waits
      d = all_dest(DIR_EAST);
      repeat (5) drive(NR'(20'h00303), NR'(20'h00303), d, "R6 hold on loss");
      d[1*DW +: DW] = DW'(DIR_LOCAL);
      repeat (4) drive(NR'(20'h00303), NR'(20'h00303), d, "R6 mixed targets");

      // R8: disabled and out-of-range outputs ignored
      drive('1, '1, all_dest(DIR_NORTH), "R8 disabled output");
      drive('1, '1, all_dest(7), "R8 out of range");
      d = all_dest(DIR_NORTH);
      d[(3*V+1)*DW +: DW] = DW'(DIR_SOUTH);
      d[(3*V+2)*DW +: DW] = DW'(6);
      repeat (3) drive(NR'(20'h0F000), NR'(20'h0F000), d, "R8 mixed with valid VC");

      // R3 and R4: irregular traffic
      for (int i = 0; i < 300; i++) begin
         logic [NR*DW-1:0] rd = '0;
         for (int k = 0; k < NR; k++) rd[k*DW +: DW] = DW'($urandom % 8);
         drive(NR'($urandom), NR'($urandom | $urandom), rd, "R3 R4 mixed traffic");
      end

      // R9: everyone aims at local output
      seen = '0;
      starve_on = 1'b1;
      repeat (20) drive('1, '1, all_dest(DIR_LOCAL), "R9 saturation");
      #5;
      starve_on = 1'b0;
      n_run++;
      if (seen !== '1) begin
         n_fail++;
         $display("FAIL R9 starvation: served=%h expected=%h", seen, {NR{1'b1}});
      end

      drive('0, '0, '0, "R2 drain");
      #5;
      finish_run();
   end
endmodule